// File: doc/BRIEF.md
# Stack Top Register Cache Execution Unit

This block executes stack-machine instructions against an evaluation stack that lives in word memory. The two topmost stack words are held in a pair of shadow registers, so most operations touch no memory. A top-of-stack pointer names the last valid word of the memory-resident part of the stack. The logical depth of the stack is that pointer's distance from a configurable base address plus the number of occupied shadow registers (0, 1 or 2).

Instructions arrive one at a time over a valid/ready handshake. They are push from a memory address, push literal, pop to a memory address, add, subtract, multiply, exponentiate, reverse-operand subtract and exponentiate, and swap. When an instruction needs a shadow slot that is taken, the deeper shadow word spills to memory. When it needs an operand that is not in a shadow register, that operand is refilled from memory. Every memory access takes exactly two cycles. When an instruction completes, the block pulses a done strobe carrying the number of cycles the instruction took. An instruction that asks for more operands than the stack holds sets a sticky underflow flag and changes nothing else.

Top module: `tos_cache_unit`

## Requirements
- R1: After reset, `stk_count` is 0, `stk_ptr` equals the base address, `underflow` is 0, `in_ready` is 1 and no memory request is made.
- R2: Push literal (`in_op`=1) costs 1 cycle when a shadow slot is free. It costs 3 cycles when both slots are full, because the deeper shadow word is first written to address `stk_ptr`+1 and `stk_ptr` then increments.
- R3: Push from memory (`in_op`=0, read address `in_addr`) costs 2 cycles with a free slot and 4 cycles when both slots are full (spill, then fetch).
- R4: A binary operation with both operands in shadow registers costs 1 cycle. The left operand is the deeper word and the right operand is the top word. The result becomes the single shadow word (`stk_count`=1).
- R5: A binary operation refills each missing operand from address `stk_ptr`, then decrements `stk_ptr`. With one operand in shadow it costs 3 cycles; with none it costs 5.
- R6: The results are taken modulo 2^DW. Add (`in_op`=3) gives left+right, subtract (4) gives left−right, multiply (6) gives left×right, and exponentiate (7) gives left raised to (right mod 2^EXPW).
- R7: Reverse subtract (5) and reverse exponentiate (8) exchange left and right at the same cost as the forward forms.
- R8: Swap (`in_op`=9) exchanges the two top words and costs the same as a binary operation. It leaves `stk_count`=2.
- R9: Pop to memory (`in_op`=2) writes the top word to `in_addr` in 2 cycles. When the shadow registers are empty it first refills from memory, for a total of 4 cycles.
- R10: An instruction that needs more words than the logical depth holds (2 for binary operations and swap, 1 for pop) costs 1 cycle. It leaves the stack unchanged and sets `underflow`, which stays set until reset.
- R11: `stk_count` never exceeds 2, and `stk_ptr` never falls below the base address. `stk_ptr`−base+`stk_count` always equals the logical depth, and values come back in last-in first-out order.
- R12: `in_ready` is high only while no instruction is executing. Each memory access holds `mem_req` for exactly 2 cycles. Each instruction produces exactly one one-cycle `done_valid` pulse, which carries the cost on `done_cycles`.
- R13: Opcodes 10 to 15 complete in 1 cycle with no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction accepted when valid |
| in_op | input | 4 | Opcode |
| in_addr | input | AW | Memory address for push/pop |
| in_lit | input | DW | Literal for push literal |
| mem_req | output | 1 | Memory access active (2 cycles per access) |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, captured on the second access cycle |
| done_valid | output | 1 | One-cycle completion strobe |
| done_cycles | output | CW | Cycle cost of the completed instruction |
| underflow | output | 1 | Sticky underflow flag |
| stk_count | output | 2 | Occupied shadow registers |
| stk_ptr | output | AW | Last valid memory-resident stack word |

## Verification
The hardest cases to reach are binary operations and swaps that find one or no operand in the shadow registers while the memory-resident stack still holds enough words. Only these cases take the 3-cycle and 5-cycle refill paths. The bench reaches them by pushing three or four values, which forces spills, and then popping one or two, which leaves the cache partly or fully empty over a non-empty memory stack. It sweeps every operator across all three occupancy levels with varied operand values, and it predicts each cost and result from an arithmetic stack model.

// File: rtl/tosc_pkg.sv
package tosc_pkg;

    localparam logic [3:0] OP_PUSHM = 4'd0;
    localparam logic [3:0] OP_PUSHL = 4'd1;
    localparam logic [3:0] OP_POPM  = 4'd2;
    localparam logic [3:0] OP_ADD   = 4'd3;
    localparam logic [3:0] OP_SUB   = 4'd4;
    localparam logic [3:0] OP_RSUB  = 4'd5;
    localparam logic [3:0] OP_MUL   = 4'd6;
    localparam logic [3:0] OP_EXP   = 4'd7;
    localparam logic [3:0] OP_REXP  = 4'd8;
    localparam logic [3:0] OP_SWAP  = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SPILL  = 3'd1,
        ST_REFILL = 3'd2,
        ST_FETCH  = 3'd3,
        ST_STORE  = 3'd4,
        ST_EXEC   = 3'd5
    } st_e;

    // Pending micro-steps of one instruction, performed in field order
    typedef struct packed {
        logic       spill;
        logic [1:0] refills;
        logic       fetch;
        logic       store;
        logic       exec;
        logic       uflow;
    } plan_t;

    function automatic logic is_arith(logic [3:0] op);
        return (op >= OP_ADD) && (op <= OP_REXP);
    endfunction

    function automatic logic is_rev(logic [3:0] op);
        return (op == OP_RSUB) || (op == OP_REXP);
    endfunction

    function automatic st_e pick_step(plan_t p);
        if (p.spill)                 return ST_SPILL;
        else if (p.refills != 2'd0)  return ST_REFILL;
        else if (p.fetch)            return ST_FETCH;
        else if (p.store)            return ST_STORE;
        else if (p.exec)             return ST_EXEC;
        else                         return ST_IDLE;
    endfunction

endpackage

// File: rtl/tosc_planner.sv
module tosc_planner
    import tosc_pkg::*;
#(
    parameter int AW   = 8,
    parameter int BASE = 128
) (
    input  logic [3:0]    op,
    input  logic [1:0]    cnt,
    input  logic [AW-1:0] ptr,
    output plan_t         plan
);
    localparam logic [AW-1:0] BASE_A = AW'(BASE);
    localparam int            XW     = AW + 2;

    logic [AW-1:0] mem_words;
    logic [XW-1:0] avail;
    logic [XW-1:0] need;

    always_comb begin
        mem_words = ptr - BASE_A;
        avail     = XW'(mem_words) + XW'(cnt);
        if (is_arith(op) || op == OP_SWAP) need = XW'(2);
        else if (op == OP_POPM)            need = XW'(1);
        else                               need = '0;
    end

    always_comb begin
        plan = '0;
        if (avail < need) begin
            plan.exec  = 1'b1;
            plan.uflow = 1'b1;
        end else begin
            unique case (op)
                OP_PUSHM: begin
                    plan.spill = (cnt == 2'd2);
                    plan.fetch = 1'b1;
                end
                OP_PUSHL: begin
                    plan.spill = (cnt == 2'd2);
                    plan.exec  = 1'b1;
                end
                OP_POPM: begin
                    plan.refills = (cnt == 2'd0) ? 2'd1 : 2'd0;
                    plan.store   = 1'b1;
                end
                OP_ADD, OP_SUB, OP_RSUB, OP_MUL, OP_EXP, OP_REXP, OP_SWAP: begin
                    plan.refills = 2'd2 - cnt;
                    plan.exec    = 1'b1;
                end
                default: plan.exec = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/tosc_alu.sv
module tosc_alu
    import tosc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int EXPW = 4
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] res
);
    // Square-and-multiply power, one stage per exponent bit
    logic [DW-1:0] acc [EXPW+1];
    logic [DW-1:0] sq  [EXPW+1];

    assign acc[0] = DW'(1);
    assign sq[0]  = lhs;

    for (genvar i = 0; i < EXPW; i++) begin : g_pow
        assign acc[i+1] = rhs[i] ? DW'(acc[i] * sq[i]) : acc[i];
        assign sq[i+1]  = DW'(sq[i] * sq[i]);
    end

    always_comb begin
        unique case (op)
            OP_ADD:           res = DW'(lhs + rhs);
            OP_SUB, OP_RSUB:  res = DW'(lhs - rhs);
            OP_MUL:           res = DW'(lhs * rhs);
            OP_EXP, OP_REXP:  res = acc[EXPW];
            default:          res = '0;
        endcase
    end
endmodule

// File: rtl/tos_cache_unit.sv
module tos_cache_unit
    import tosc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 8,
    parameter int BASE = 128,
    parameter int EXPW = 4,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [3:0]    in_op,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_lit,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done_valid,
    output logic [CW-1:0] done_cycles,
    output logic          underflow,
    output logic [1:0]    stk_count,
    output logic [AW-1:0] stk_ptr
);
    localparam logic [AW-1:0] BASE_A = AW'(BASE);

    typedef struct packed {
        st_e           st;
        logic          ph;
        plan_t         pend;
        logic [3:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] lit;
        logic [DW-1:0] sh0;      // top word
        logic [DW-1:0] sh1;      // word below top
        logic [1:0]    cnt;
        logic [AW-1:0] ptr;
        logic [CW-1:0] cyc;
        logic          uflow;
        logic          done;
        logic [CW-1:0] done_cyc;
    } regs_t;

    regs_t q, n;
    plan_t plan;
    logic  step_end;
    logic  [DW-1:0] alu_l, alu_r, alu_res;
    logic           req_c, we_c;
    logic  [AW-1:0] addr_c;
    logic  [DW-1:0] wdata_c;

    tosc_planner #(.AW(AW), .BASE(BASE)) u_plan (
        .op   (in_op),
        .cnt  (q.cnt),
        .ptr  (q.ptr),
        .plan (plan)
    );

    assign alu_l = is_rev(q.op) ? q.sh0 : q.sh1;
    assign alu_r = is_rev(q.op) ? q.sh1 : q.sh0;

    tosc_alu #(.DW(DW), .EXPW(EXPW)) u_alu (
        .op  (q.op),
        .lhs (alu_l),
        .rhs (alu_r),
        .res (alu_res)
    );

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        step_end = 1'b0;
        req_c    = 1'b0;
        we_c     = 1'b0;
        addr_c   = q.addr;
        wdata_c  = q.sh0;

        unique case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    n.op   = in_op;
                    n.addr = in_addr;
                    n.lit  = in_lit;
                    n.pend = plan;
                    n.cyc  = '0;
                    n.ph   = 1'b0;
                    n.st   = pick_step(plan);
                end
            end
            ST_SPILL: begin
                req_c   = 1'b1;
                we_c    = 1'b1;
                addr_c  = q.ptr + AW'(1);
                wdata_c = q.sh1;
                if (q.ph) begin
                    n.ptr        = q.ptr + AW'(1);
                    n.cnt        = 2'd1;
                    n.pend.spill = 1'b0;
                    step_end     = 1'b1;
                end
            end
            ST_REFILL: begin
                req_c  = 1'b1;
                addr_c = q.ptr;
                if (q.ph) begin
                    n.ptr = q.ptr - AW'(1);
                    if (q.cnt == 2'd1) begin
                        n.sh1 = mem_rdata;
                        n.cnt = 2'd2;
                    end else begin
                        n.sh0 = mem_rdata;
                        n.cnt = 2'd1;
                    end
                    n.pend.refills = q.pend.refills - 2'd1;
                    step_end       = 1'b1;
                end
            end
            ST_FETCH: begin
                req_c  = 1'b1;
                addr_c = q.addr;
                if (q.ph) begin
                    n.sh1        = q.sh0;
                    n.sh0        = mem_rdata;
                    n.cnt        = q.cnt + 2'd1;
                    n.pend.fetch = 1'b0;
                    step_end     = 1'b1;
                end
            end
            ST_STORE: begin
                req_c   = 1'b1;
                we_c    = 1'b1;
                addr_c  = q.addr;
                wdata_c = q.sh0;
                if (q.ph) begin
                    n.sh0        = q.sh1;
                    n.cnt        = q.cnt - 2'd1;
                    n.pend.store = 1'b0;
                    step_end     = 1'b1;
                end
            end
            ST_EXEC: begin
                n.pend.exec = 1'b0;
                step_end    = 1'b1;
                if (q.pend.uflow) begin
                    n.uflow = 1'b1;
                end else if (q.op == OP_PUSHL) begin
                    n.sh1 = q.sh0;
                    n.sh0 = q.lit;
                    n.cnt = q.cnt + 2'd1;
                end else if (is_arith(q.op)) begin
                    n.sh0 = alu_res;
                    n.cnt = 2'd1;
                end else if (q.op == OP_SWAP) begin
                    n.sh0 = q.sh1;
                    n.sh1 = q.sh0;
                end
            end
            default: n.st = ST_IDLE;
        endcase

        if (q.st != ST_IDLE) begin
            n.cyc = q.cyc + CW'(1);
            n.ph  = step_end ? 1'b0 : ~q.ph;
            if (step_end) begin
                n.st = pick_step(n.pend);
                if (pick_step(n.pend) == ST_IDLE) begin
                    n.done     = 1'b1;
                    n.done_cyc = q.cyc + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.ptr <= BASE_A;
        end else begin
            q <= n;
        end
    end

    assign in_ready    = (q.st == ST_IDLE);
    assign mem_req     = req_c;
    assign mem_we      = we_c;
    assign mem_addr    = addr_c;
    assign mem_wdata   = wdata_c;
    assign done_valid  = q.done;
    assign done_cycles = q.done_cyc;
    assign underflow   = q.uflow;
    assign stk_count   = q.cnt;
    assign stk_ptr     = q.ptr;
endmodule

// File: rtl/tosc_chk.sv
module tosc_chk #(
    parameter int AW   = 8,
    parameter int BASE = 128,
    parameter int CW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic          done_valid,
    input logic [CW-1:0] done_cycles,
    input logic          underflow,
    input logic [1:0]    stk_count,
    input logic [AW-1:0] stk_ptr
);
    logic par_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       par_q <= 1'b0;
        else if (mem_req) par_q <= ~par_q;
        else              par_q <= 1'b0;
    end

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count != 2'd3);

    // R11
    ptr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ptr >= AW'(BASE));

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((stk_count == 2'd2 && $past(stk_count) == 2'd0) ||
          (stk_count == 2'd0 && $past(stk_count) == 2'd2)));

    // R10
    sticky_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R12
    idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req);

    // R12
    mem_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> !par_q);

    // R12
    write_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> in_ready);

    // R5
    cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_cycles >= CW'(1) && done_cycles <= CW'(5)));
endmodule

bind tos_cache_unit tosc_chk #(.AW(AW), .BASE(BASE), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .done_valid  (done_valid),
    .done_cycles (done_cycles),
    .underflow   (underflow),
    .stk_count   (stk_count),
    .stk_ptr     (stk_ptr)
);

// File: tb/sim_tos_cache_unit.sv
`timescale 1ns/1ps
module sim_tos_cache_unit;
    localparam int DW = 16, AW = 8, BASE = 128, EXPW = 4, CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [3:0]    in_op = '0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_lit = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          done_valid, underflow;
    logic [CW-1:0] done_cycles;
    logic [1:0]    stk_count;
    logic [AW-1:0] stk_ptr;

    logic [DW-1:0] bmem [0:255];
    assign mem_rdata = bmem[mem_addr];
    always @(posedge clk) if (mem_req && mem_we) bmem[mem_addr] <= mem_wdata;

    always #2.5 clk = ~clk;

    tos_cache_unit #(.DW(DW), .AW(AW), .BASE(BASE), .EXPW(EXPW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .in_lit(in_lit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_cycles(done_cycles),
        .underflow(underflow), .stk_count(stk_count), .stk_ptr(stk_ptr)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    int mcnt = 0, mptr = 0, ld = 0;
    bit muf = 0;
    logic [15:0] lstk [0:63];
    int unsigned seed = 32'h1234_5678;

    function automatic logic [15:0] nxt();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:8];
    endfunction

    function automatic logic [15:0] pw(logic [15:0] b, int e);
        longint r = 1;
        for (int i = 0; i < e; i++) r = (r * b) & 16'hFFFF;
        return r[15:0];
    endfunction

    function automatic logic [15:0] calc(logic [3:0] op, logic [15:0] a, logic [15:0] b);
        case (op)
            4'd3: return a + b;
            4'd4: return a - b;
            4'd5: return b - a;
            4'd6: return 16'((longint'(a) * longint'(b)) & 16'hFFFF);
            4'd7: return pw(a, b % 16);
            4'd8: return pw(b, a % 16);
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input int addr, input logic [15:0] lit,
                         input string tag);
        int ecost = 1, need = 0, k = 0, miss = 0;
        bit is_pop = 0;
        logic [15:0] eval = '0, a, b;
        if (op >= 4'd3 && op <= 4'd9) need = 2;
        else if (op == 4'd2) need = 1;
        if (mptr + mcnt < need) begin
            muf = 1;
        end else if (op == 4'd0 || op == 4'd1) begin
            ecost = ((mcnt == 2) ? 2 : 0) + ((op == 4'd0) ? 2 : 1);
            if (mcnt == 2) mptr++; else mcnt++;
            lstk[ld] = (op == 4'd0) ? bmem[addr] : lit;
            ld++;
        end else if (op == 4'd2) begin
            ecost = (mcnt == 0) ? 4 : 2;
            if (mcnt == 0) mptr--; else mcnt--;
            ld--;
            eval = lstk[ld];
            is_pop = 1;
        end else if (op <= 4'd9) begin
            miss = 2 - mcnt;
            ecost = 2 * miss + 1;
            mptr -= miss;
            a = lstk[ld-2];
            b = lstk[ld-1];
            if (op == 4'd9) begin
                mcnt = 2;
                lstk[ld-2] = b;
                lstk[ld-1] = a;
            end else begin
                mcnt = 1;
                ld--;
                lstk[ld-1] = calc(op, a, b);
            end
        end
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_addr = addr[AW-1:0]; in_lit = lit;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        forever begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (done_valid || k > 30) break;
            chk(!in_ready, "R12", "ready while busy", in_ready, 0);
        end
        chk(k == ecost, tag, "latency", k, ecost);
        chk(done_cycles == CW'(ecost), tag, "reported cost", done_cycles, ecost);
        chk(in_ready, "R12", "ready at done", in_ready, 1);
        chk(stk_count == 2'(mcnt), "R11", "shadow count", stk_count, mcnt);
        chk(stk_ptr == AW'(BASE + mptr), "R11", "pointer", stk_ptr, BASE + mptr);
        chk(underflow == muf, "R10", "underflow flag", underflow, muf);
        if (is_pop) chk(bmem[addr] == eval, tag, "popped value", bmem[addr], eval);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stk_count == 0, "R1", "reset count", stk_count, 0);
        chk(stk_ptr == AW'(BASE), "R1", "reset pointer", stk_ptr, BASE);
        chk(!underflow, "R1", "reset underflow", underflow, 0);
        chk(in_ready, "R1", "reset ready", in_ready, 1);
        chk(!mem_req && !done_valid, "R1", "reset idle", mem_req, 0);

        // Sweep every operator over all shadow occupancy levels
        for (int opi = 3; opi <= 9; opi++) begin
            for (int c = 0; c < 3; c++) begin
                for (int t = 0; t < 4; t++) begin
                    string tg;
                    for (int i = 0; i < 4 - c; i++) begin
                        logic [15:0] v = nxt();
                        if (t == 1) v = v % 16;
                        if (i % 2 == 1) begin
                            bmem[i] = v;
                            issue(4'd0, i, 16'd0, "R3");
                        end else begin
                            issue(4'd1, 0, v, "R2");
                        end
                    end
                    for (int i = 0; i < 2 - c; i++) issue(4'd2, 64 + i, 16'd0, "R9");
                    if (opi == 5 || opi == 8) tg = "R7";
                    else if (opi == 9) tg = "R8";
                    else if (opi == 4 || opi == 7) tg = "R6";
                    else if (c == 2) tg = "R4";
                    else tg = "R5";
                    issue(4'(opi), 0, 16'd0, tg);
                    issue(4'd2, 80, 16'd0, tg);
                    while (ld > 0) issue(4'd2, 81, 16'd0, "R9");
                end
            end
        end

        // Deep stack: many spills then LIFO drain
        for (int i = 0; i < 10; i++) issue(4'd1, 0, 16'(100 + i), "R2");
        issue(4'd3, 0, 16'd0, "R4");
        issue(4'd9, 0, 16'd0, "R8");
        issue(4'd4, 0, 16'd0, "R6");
        while (ld > 0) issue(4'd2, 90, 16'd0, "R11");

        // Undefined opcodes leave the stack alone
        issue(4'd1, 0, 16'hBEEF, "R2");
        for (int u = 10; u < 16; u++) issue(4'(u), 0, 16'd0, "R13");
        issue(4'd2, 91, 16'd0, "R13");

        // Underflow: sticky and non-destructive
        issue(4'd3, 0, 16'd0, "R10");
        issue(4'd1, 0, 16'h0042, "R2");
        issue(4'd4, 0, 16'd0, "R10");
        issue(4'd2, 92, 16'd0, "R10");
        issue(4'd2, 93, 16'd0, "R10");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule